// File: doc/BRIEF.md
# Dual-Area Audio DMA Address Sequencer

This block produces the memory fetch addresses for one audio stream. Software describes two memory areas, each with a base address and a byte length. The sequencer then walks through the first area, moves to the second without losing a cycle, returns to the first, and keeps alternating in this way. Each area has its own completion flag. The flags drive a single interrupt line, and software clears a flag by writing a one to its bit.

Software controls the block through an indexed register port with eight word registers. A run bit starts the walk and pauses it. Two format bits select the sample size and the channel count, and these set how far the address moves for each sample fetched. The block raises a fetch request while it is running. Every grant consumes one sample, and the address advances by one step. The current absolute address and the offset within the active area can both be read back. A read returns data one clock after the index is presented.

Register indices: 0 control, 1 interrupt, 2 base of area A, 3 base of area B, 4 lengths, 5 format, 6 current address (read-only), 7 current offset (read-only).

Top module: `adma_seq`

## Requirements
- R1: After reset, every register reads zero, and `fetch_req`, `irq` and `fetch_addr` are zero.
- R2: Indices 2 and 3 hold the bases of areas A and B. Index 4 holds the length of area A in bits 15:0 and the length of area B in bits 31:16. All three read back as written, and writes to indices 6 and 7 are ignored.
- R3: Only bit 0 of the control register (index 0) enables the walk, and `fetch_req` follows that bit from the clock after the write. The other control bits cannot be written and read as zero.
- R4: In the format register (index 5), bit 4 selects 16-bit samples and bit 5 selects stereo. The step per sample is 1 byte for 8-bit mono, 2 bytes for 16-bit mono or 8-bit stereo, and 4 bytes for 16-bit stereo. The other format bits read as zero.
- R5: `fetch_addr` is the base of the active area plus the current offset. Each clock in which `fetch_req` and `fetch_gnt` are both high advances the offset by the step.
- R6: When offset plus step reaches or passes the active area's length, the next address is the other area's base with offset 0. A length of 0 or 1 gives a one-sample area.
- R7: When area A completes, interrupt bit 1 (index 1) is set. When area B completes, interrupt bit 2 is set. `irq` is high whenever either bit is set.
- R8: Writing a one to an interrupt bit clears that bit, and writing a zero leaves it unchanged. Writing all ones clears both bits. A completion in the same clock as a clear leaves the bit set. All other interrupt bits read as zero.
- R9: With the run bit cleared, grants are ignored and the offset and active area hold. Setting the run bit again resumes from the same address.
- R10: If an area completes while its flag is still set, the flag stays set and no other register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the index presented in the previous clock |
| fetch_req | output | 1 | Sample fetch request, high while running |
| fetch_gnt | input | 1 | Grant; consumes one sample at the current address |
| fetch_addr | output | 32 | Address of the sample to fetch |
| irq | output | 1 | Any completion flag pending |

## Verification
If the offset counter or the area selector holds a wrong value, `fetch_addr` shows the error in the same cycle. The offset read-back shows it one clock later. A wrong completion decision shows up at the first grant that should have moved to the other area: `fetch_addr` fails to jump to the other base, and `irq` stays low or rises one grant too early. A wrongly kept or lost flag bit is visible on the interrupt register read that follows the acknowledge write.

// File: rtl/adma_pkg.sv
package adma_pkg;
  typedef enum logic [2:0] {
    IDX_CTRL   = 3'd0,
    IDX_IRQ    = 3'd1,
    IDX_BASE_A = 3'd2,
    IDX_BASE_B = 3'd3,
    IDX_LENS   = 3'd4,
    IDX_FMT    = 3'd5,
    IDX_CADDR  = 3'd6,
    IDX_COFS   = 3'd7
  } reg_idx_e;

  localparam int FMT_WIDE_BIT   = 4;
  localparam int FMT_STEREO_BIT = 5;
  localparam int IRQ_A_BIT      = 1;
  localparam int IRQ_B_BIT      = 2;

  // bytes consumed per sample
  function automatic logic [2:0] step_bytes(input logic wide, input logic stereo);
    case ({wide, stereo})
      2'b00:   return 3'd1;
      2'b11:   return 3'd4;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/adma_regs.sv
module adma_regs
  import adma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              run,
  output logic [ADDR_W-1:0] base_a,
  output logic [ADDR_W-1:0] base_b,
  output logic [LEN_W-1:0]  len_a,
  output logic [LEN_W-1:0]  len_b,
  output logic              wide,
  output logic              stereo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      base_a <= '0;
      base_b <= '0;
      len_a  <= '0;
      len_b  <= '0;
      wide   <= 1'b0;
      stereo <= 1'b0;
    end else if (wr) begin
      case (idx)
        IDX_CTRL:   run    <= wdata[0];
        IDX_BASE_A: base_a <= wdata[ADDR_W-1:0];
        IDX_BASE_B: base_b <= wdata[ADDR_W-1:0];
        IDX_LENS: begin
          len_a <= wdata[LEN_W-1:0];
          len_b <= wdata[2*LEN_W-1:LEN_W];
        end
        IDX_FMT: begin
          wide   <= wdata[FMT_WIDE_BIT];
          stereo <= wdata[FMT_STEREO_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adma_walker.sv
module adma_walker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              gnt,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [LEN_W-1:0]  len_a,
  input  logic [LEN_W-1:0]  len_b,
  output logic [LEN_W-1:0]  ofs,
  output logic              area,
  output logic              done,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [LEN_W:0]  ofs_sum;
  logic [LEN_W-1:0] len_act;
  logic            wrap;
  logic            adv;

  assign ofs_sum  = {1'b0, ofs} + (LEN_W+1)'(step);
  assign len_act  = area ? len_b : len_a;
  assign wrap     = ofs_sum >= {1'b0, len_act};
  assign adv      = run & gnt;
  assign done     = adv & wrap;
  assign cur_addr = (area ? base_b : base_a) + ADDR_W'(ofs);

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs  <= '0;
      area <= 1'b0;
    end else if (adv) begin
      if (wrap) begin
        ofs  <= '0;
        area <= ~area;
      end else begin
        ofs <= ofs_sum[LEN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/adma_irq.sv
module adma_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= set[i] | (pend[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(set | (pend & ~clr));
  end
endmodule

// File: rtl/adma_seq.sv
module adma_seq
  import adma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fetch_req,
  input  logic              fetch_gnt,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              irq
);
  localparam int NSRC = 2;

  logic              run_q;
  logic [ADDR_W-1:0] base_a, base_b;
  logic [LEN_W-1:0]  len_a, len_b;
  logic              wide, stereo;
  logic [2:0]        step;
  logic [LEN_W-1:0]  ofs;
  logic              area;
  logic              done;
  logic [ADDR_W-1:0] cur_addr;
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   set_v;
  logic [NSRC-1:0]   clr_v;

  adma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .run(run_q), .base_a(base_a), .base_b(base_b), .len_a(len_a), .len_b(len_b),
    .wide(wide), .stereo(stereo)
  );

  assign step = step_bytes(wide, stereo);

  adma_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst), .run(run_q), .gnt(fetch_gnt), .step(step),
    .base_a(base_a), .base_b(base_b), .len_a(len_a), .len_b(len_b),
    .ofs(ofs), .area(area), .done(done), .cur_addr(cur_addr)
  );

  assign set_v = {done & area, done & ~area};
  assign clr_v = (reg_wr && reg_idx == IDX_IRQ) ?
                 {reg_wdata[IRQ_B_BIT], reg_wdata[IRQ_A_BIT]} : '0;

  adma_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .set(set_v), .clr(clr_v), .pend(pend), .irq(irq)
  );

  assign fetch_req  = run_q;
  assign fetch_addr = cur_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_idx)
        IDX_CTRL:   reg_rdata <= DATA_W'(run_q);
        IDX_IRQ:    reg_rdata <= DATA_W'({pend, 1'b0});
        IDX_BASE_A: reg_rdata <= DATA_W'(base_a);
        IDX_BASE_B: reg_rdata <= DATA_W'(base_b);
        IDX_LENS:   reg_rdata <= DATA_W'({len_b, len_a});
        IDX_FMT:    reg_rdata <= DATA_W'({stereo, wide, 4'b0000});
        IDX_CADDR:  reg_rdata <= DATA_W'(cur_addr);
        default:    reg_rdata <= DATA_W'(ofs);
      endcase
    end
  end
endmodule

// File: rtl/adma_seq_chk.sv
module adma_seq_chk #(
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              gnt,
  input logic              done,
  input logic              area,
  input logic [LEN_W-1:0]  ofs,
  input logic [2:0]        step,
  input logic [1:0]        pend,
  input logic              wr,
  input logic [2:0]        idx,
  input logic [DATA_W-1:0] wdata
);
  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (run && gnt && !done) |=> ofs == $past(ofs) + LEN_W'($past(step)));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> (ofs == '0) && (area != $past(area)));

  assert_set_a_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !area) |=> pend[0]);

  assert_set_b_R7: assert property (@(posedge clk) disable iff (rst)
    (done && area) |=> pend[1]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(ofs) && $stable(area));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && !(wr && idx == 3'd1 && wdata[1])) |=> pend[0]);
endmodule

bind adma_seq adma_seq_chk #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .run(run_q), .gnt(fetch_gnt), .done(done),
  .area(area), .ofs(ofs), .step(step), .pend(pend),
  .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata)
);

// File: tb/sim_adma_seq.sv
module sim_adma_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_req;
  logic        fetch_gnt = 1'b0;
  logic [31:0] fetch_addr;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  adma_seq u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
    .fetch_gnt(fetch_gnt), .fetch_addr(fetch_addr), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] i, input logic [31:0] d);
    reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] i, output logic [31:0] d);
    reg_idx = i;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic grant(input int n);
    for (int k = 0; k < n; k++) begin
      fetch_gnt = 1'b1;
      @(negedge clk);
    end
    fetch_gnt = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      rd_reg(3'(i), v);
      chk($sformatf("R1 reg %0d after reset", i), v, 32'h0);
    end
    chk("R1 fetch_req", {31'b0, fetch_req}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fetch_addr", fetch_addr, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    do_reset();
    wr_reg(3'd2, 32'hA5A0_1234);
    wr_reg(3'd3, 32'h5A5F_0008);
    wr_reg(3'd4, 32'h0030_0010);
    wr_reg(3'd6, 32'hFFFF_FFFF);
    wr_reg(3'd7, 32'hFFFF_FFFF);
    rd_reg(3'd2, v); chk("R2 base A", v, 32'hA5A0_1234);
    rd_reg(3'd3, v); chk("R2 base B", v, 32'h5A5F_0008);
    rd_reg(3'd4, v); chk("R2 lengths", v, 32'h0030_0010);
    rd_reg(3'd6, v); chk("R2 cur addr write ignored", v, 32'hA5A0_1234);
    rd_reg(3'd7, v); chk("R2 cur offset write ignored", v, 32'h0);
    wr_reg(3'd0, 32'hFFFF_FFFE);
    chk("R3 req with bit0 clear", {31'b0, fetch_req}, 0);
    rd_reg(3'd0, v); chk("R3 control upper bits", v, 32'h0);
    wr_reg(3'd0, 32'hFFFF_FFFF);
    chk("R3 req with bit0 set", {31'b0, fetch_req}, 1);
    rd_reg(3'd0, v); chk("R3 control readback", v, 32'h1);
  endtask

  task automatic t_format(input logic [31:0] fmt, input logic [31:0] step);
    logic [31:0] v;
    do_reset();
    wr_reg(3'd2, 32'h0000_4000);
    wr_reg(3'd4, 32'h0100_0100);
    wr_reg(3'd5, fmt);
    rd_reg(3'd5, v); chk("R4 format readback", v, fmt & 32'h30);
    wr_reg(3'd0, 32'h1);
    grant(2);
    rd_reg(3'd7, v); chk($sformatf("R4 offset fmt %h", fmt), v, 2 * step);
    chk("R5 address = base + offset", fetch_addr, 32'h4000 + 2 * step);
  endtask

  task automatic t_walk();
    logic [31:0] v;
    do_reset();
    wr_reg(3'd2, 32'h0000_1000);
    wr_reg(3'd3, 32'h0000_2000);
    wr_reg(3'd4, 32'h0006_0008);
    wr_reg(3'd5, 32'h30);
    wr_reg(3'd0, 32'h1);
    chk("R5 first address", fetch_addr, 32'h1000);
    grant(1);
    chk("R5 second address", fetch_addr, 32'h1004);
    chk("R7 no irq mid area", {31'b0, irq}, 0);
    grant(1);
    chk("R6 switch to B", fetch_addr, 32'h2000);
    chk("R7 irq after A", {31'b0, irq}, 1);
    rd_reg(3'd1, v); chk("R7 flag A", v, 32'h2);
    grant(1);
    chk("R5 inside B", fetch_addr, 32'h2004);
    grant(1);
    chk("R6 back to A", fetch_addr, 32'h1000);
    rd_reg(3'd1, v); chk("R7 both flags", v, 32'h6);
    rd_reg(3'd7, v); chk("R6 offset zero after switch", v, 32'h0);
    wr_reg(3'd1, 32'h2);
    rd_reg(3'd1, v); chk("R8 clear A only", v, 32'h4);
    wr_reg(3'd1, 32'h0);
    rd_reg(3'd1, v); chk("R8 zero write no effect", v, 32'h4);
    wr_reg(3'd1, 32'hFFFF_FFFF);
    rd_reg(3'd1, v); chk("R8 all ones clears", v, 32'h0);
    chk("R8 irq low after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_pause();
    logic [31:0] v;
    do_reset();
    wr_reg(3'd2, 32'h0000_0100);
    wr_reg(3'd4, 32'h0040_0040);
    wr_reg(3'd0, 32'h1);
    grant(3);
    wr_reg(3'd0, 32'h0);
    chk("R9 req low while paused", {31'b0, fetch_req}, 0);
    grant(2);
    rd_reg(3'd7, v); chk("R9 offset held", v, 32'h3);
    chk("R9 address held", fetch_addr, 32'h103);
    wr_reg(3'd0, 32'h1);
    grant(1);
    chk("R9 resume same place", fetch_addr, 32'h104);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    do_reset();
    wr_reg(3'd2, 32'h10);
    wr_reg(3'd3, 32'h20);
    wr_reg(3'd4, 32'h0000_0001);
    wr_reg(3'd0, 32'h1);
    grant(1);
    chk("R6 zero/one length switches", fetch_addr, 32'h20);
    grant(2);
    chk("R10 third switch", fetch_addr, 32'h20);
    rd_reg(3'd1, v); chk("R10 flags stay, nothing extra", v, 32'h6);
    grant(1);
    // A completes in the same clock as a clear of bit 1
    reg_wr = 1'b1; reg_idx = 3'd1; reg_wdata = 32'h2; fetch_gnt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; fetch_gnt = 1'b0;
    rd_reg(3'd1, v); chk("R8 set wins over clear", v, 32'h6);
    rd_reg(3'd6, v); chk("R10 address unaffected", v, 32'h20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_regs();
    t_format(32'h00, 1);
    t_format(32'h10, 2);
    t_format(32'h20, 2);
    t_format(32'hFF, 4);
    t_walk();
    t_pause();
    t_sticky();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule